// File: doc/BRIEF.md
# Port Pin Interrupt Controller

This block turns eight general-purpose port pins into interrupt sources. Each pin is brought into the clock domain by a synchronizer chain. A per-pin sense bit chooses which transition of that pin counts as the start of a request. When that transition arrives, a pending flag for the pin is latched. Software reaches four byte-wide registers through a small read/write port. They hold the sense bits, the pending flags, the per-pin enables and the per-pin priority bits.

The pending, enabled sources are combined with a global enable taken from the CPU core and arbitrated over two priority levels. The block presents one request at a time, with its level and a 3-bit vector index. The CPU answers with an acknowledge when it enters a service routine and with a return when it leaves one. The block tracks which levels are in service, so a high-priority source can interrupt a low-priority routine but nothing can interrupt a high-priority one.

While the device is powered down, a combinational wake-up output rises as soon as an enabled pin sits at its active level. It needs no running clock.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset all four registers read 00h, no request is presented and no level is in service.
- R2: Register address 0 holds the sense bits, 1 the pending flags, 2 the enables and 3 the priority bits. Bit i of each register belongs to pin i. reg_rdata shows the addressed register combinationally, and a write takes effect at the next clock edge.
- R3: A pin's flag is set at the third rising clock edge after the pin enters its active level. Sense 0 makes the high level active (a low-to-high move sets the flag). Sense 1 makes the low level active. Holding the level does not set the flag again, and rewriting the sense bit never sets a flag on its own.
- R4: Software writes to the flag register load the written value, so a 1 raises a request from software. A hardware set in the same cycle as a software write of 0 wins, and the flag ends up set.
- R5: A source can be presented only when its flag, its enable bit and the global enable are all 1.
- R6: Any high-priority source (priority bit 1) is presented before all low-priority ones. Within one level the lowest-numbered pin wins. irq_vec carries the pin number and irq_hi carries the level.
- R7: Once a low-priority request is acknowledged, only high-priority requests are presented. Once a high-priority request is acknowledged, no request is presented.
- R8: Acknowledge leaves the pending flags unchanged. Only software clears them.
- R9: A return ends the innermost service in progress: high level first, then low level.
- R10: While power_down is 1 and global enable is 1, wake is 1 whenever some enabled pin is at its active level or has its flag set. This path has no clocked element. wake is 0 while power_down is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Selected register contents |
| pins | input | 8 | Port pins used as interrupt inputs |
| glb_en | input | 1 | Global interrupt enable from the CPU core |
| ack | input | 1 | CPU accepts the presented request |
| ret | input | 1 | CPU leaves the current service routine |
| power_down | input | 1 | Device is in power-down |
| irq_req | output | 1 | A request is presented |
| irq_hi | output | 1 | Presented request is high priority |
| irq_vec | output | 3 | Pin number of the presented request |
| wake | output | 1 | Asynchronous wake-up request |

## Verification
A pin transition detected by the synchronizer can land on the same clock edge as a software write that clears the flag register. The bench provokes this by raising a pin and timing a write of 00h so that it completes on the third edge after the pin change. It then reads the flag register and expects the hardware set to have survived. A second overlap is an acknowledge of a low-level request followed by a high-level flag rising while that service is open. The bench judges this from irq_req, irq_hi and irq_vec after each acknowledge and return.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
   typedef enum logic [1:0] {
      RA_SENSE = 2'd0,
      RA_FLAG  = 2'd1,
      RA_EN    = 2'd2,
      RA_PRIO  = 2'd3
   } reg_addr_e;
endpackage

// File: rtl/pirq_sync_edge.sv
module pirq_sync_edge #(
   parameter int N      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] pin_i,
   input  logic [N-1:0] sense_i,
   output logic [N-1:0] lvl_o,
   output logic [N-1:0] edge_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pirq_sync_edge: STAGES must be at least 2");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic [STAGES-1:0] sh;
      logic              last;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sh   <= '0;
            last <= 1'b0;
         end else begin
            sh   <= {sh[STAGES-2:0], pin_i[i]};
            last <= sh[STAGES-1];
         end
      end
      assign lvl_o[i]  = sh[STAGES-1];
      // active now, inactive one cycle ago, both judged with the current sense
      assign edge_o[i] = (sh[STAGES-1] ^ sense_i[i]) & ~(last ^ sense_i[i]);

      p_edge_single_r3 : assert property (@(posedge clk) disable iff (!rst_n)
         edge_o[i] |=> !edge_o[i]);
   end
endmodule

// File: rtl/pirq_arbiter.sv
module pirq_arbiter #(
   parameter int N  = 8,
   parameter int VW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req_i,
   input  logic [N-1:0]  prio_i,
   input  logic          ack_i,
   input  logic          ret_i,
   output logic          irq_req_o,
   output logic          irq_hi_o,
   output logic [VW-1:0] irq_vec_o
);
   logic [N-1:0]  hi_set, lo_set;
   logic          hit_hi, hit_lo;
   logic [VW-1:0] idx_hi, idx_lo;
   logic          in_hi, in_lo;

   assign hi_set = req_i & prio_i;
   assign lo_set = req_i & ~prio_i;

   // lowest index wins inside each level
   always_comb begin
      hit_hi = 1'b0; idx_hi = '0;
      hit_lo = 1'b0; idx_lo = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (hi_set[i]) begin hit_hi = 1'b1; idx_hi = VW'(i); end
         if (lo_set[i]) begin hit_lo = 1'b1; idx_lo = VW'(i); end
      end
   end

   always_comb begin
      irq_req_o = 1'b0;
      irq_hi_o  = 1'b0;
      irq_vec_o = '0;
      if (hit_hi && !in_hi) begin
         irq_req_o = 1'b1;
         irq_hi_o  = 1'b1;
         irq_vec_o = idx_hi;
      end else if (hit_lo && !in_hi && !in_lo) begin
         irq_req_o = 1'b1;
         irq_vec_o = idx_lo;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_hi <= 1'b0;
         in_lo <= 1'b0;
      end else if (ack_i && irq_req_o) begin
         if (irq_hi_o) in_hi <= 1'b1;
         else          in_lo <= 1'b1;
      end else if (ret_i) begin
         if (in_hi)      in_hi <= 1'b0;
         else if (in_lo) in_lo <= 1'b0;
      end
   end

   p_ack_valid_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      ack_i |-> irq_req_o);
   p_no_lo_in_service_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (in_lo || in_hi) |-> !(irq_req_o && !irq_hi_o));
   p_no_pre_empt_hi_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      in_hi |-> !irq_req_o);
   p_req_pending_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      irq_req_o |-> req_i[irq_vec_o]);
   p_level_match_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      irq_req_o |-> (irq_hi_o == prio_i[irq_vec_o]));
   p_ret_pops_hi_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (ret_i && !ack_i && in_hi) |=> (!in_hi && (in_lo == $past(in_lo))));
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
   import pirq_pkg::*;
#(
   parameter int NUM_SRC     = 8,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit WAKE_ASYNC  = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       reg_wr,
   input  logic [1:0]                 reg_addr,
   input  logic [DATA_W-1:0]          reg_wdata,
   output logic [DATA_W-1:0]          reg_rdata,
   input  logic [NUM_SRC-1:0]         pins,
   input  logic                       glb_en,
   input  logic                       ack,
   input  logic                       ret,
   input  logic                       power_down,
   output logic                       irq_req,
   output logic                       irq_hi,
   output logic [$clog2(NUM_SRC)-1:0] irq_vec,
   output logic                       wake
);
   localparam int VW = $clog2(NUM_SRC);

   if (DATA_W != NUM_SRC) begin : g_bad_width
      $error("pin_irq_ctrl: DATA_W must equal NUM_SRC");
   end
   if (NUM_SRC < 2) begin : g_bad_count
      $error("pin_irq_ctrl: NUM_SRC must be at least 2");
   end

   logic [NUM_SRC-1:0] sense_q, flag_q, en_q, prio_q;
   logic [NUM_SRC-1:0] lvl_w, edge_w, req_w;
   logic               wr_flag;

   pirq_sync_edge #(.N(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_i(pins), .sense_i(sense_q),
      .lvl_o(lvl_w), .edge_o(edge_w));

   assign wr_flag = reg_wr && (reg_addr == RA_FLAG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sense_q <= '0;
         flag_q  <= '0;
         en_q    <= '0;
         prio_q  <= '0;
      end else begin
         if (reg_wr && reg_addr == RA_SENSE) sense_q <= reg_wdata;
         if (reg_wr && reg_addr == RA_EN)    en_q    <= reg_wdata;
         if (reg_wr && reg_addr == RA_PRIO)  prio_q  <= reg_wdata;
         flag_q <= (wr_flag ? reg_wdata : flag_q) | edge_w;
      end
   end

   always_comb begin
      unique case (reg_addr)
         RA_SENSE: reg_rdata = sense_q;
         RA_FLAG:  reg_rdata = flag_q;
         RA_EN:    reg_rdata = en_q;
         default:  reg_rdata = prio_q;
      endcase
   end

   assign req_w = flag_q & en_q & {NUM_SRC{glb_en}};

   pirq_arbiter #(.N(NUM_SRC), .VW(VW)) u_arb (
      .clk(clk), .rst_n(rst_n), .req_i(req_w), .prio_i(prio_q),
      .ack_i(ack), .ret_i(ret),
      .irq_req_o(irq_req), .irq_hi_o(irq_hi), .irq_vec_o(irq_vec));

   if (WAKE_ASYNC) begin : g_wake_async
      assign wake = power_down & glb_en & (|(en_q & ((pins ^ sense_q) | flag_q)));
   end else begin : g_wake_sync
      assign wake = power_down & glb_en & (|(en_q & ((lvl_w ^ sense_q) | flag_q)));
   end

   p_set_wins_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (|edge_w) |=> ((flag_q & $past(edge_w)) == $past(edge_w)));
   p_flag_sticky_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      !wr_flag |=> (($past(flag_q) & ~flag_q) == '0));
   p_wake_off_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      !power_down |-> !wake);
   p_req_gated_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      !glb_en |-> !irq_req);
endmodule

// File: tb/sim_pin_irq_ctrl.sv
module sim_pin_irq_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic [7:0] pins = 8'h00;
   logic       glb_en = 1'b1;
   logic       ack = 1'b0;
   logic       ret = 1'b0;
   logic       power_down = 1'b0;
   logic       irq_req, irq_hi, wake;
   logic [2:0] irq_vec;
   int         n_chk = 0;
   int         n_err = 0;

   always #5 clk = ~clk;

   pin_irq_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pins(pins),
      .glb_en(glb_en), .ack(ack), .ret(ret), .power_down(power_down),
      .irq_req(irq_req), .irq_hi(irq_hi), .irq_vec(irq_vec), .wake(wake));

   // sense, enable, priority, pins, expected flags, {req, hi, 000, vec}
   localparam logic [47:0] VEC [6] = '{
      {8'h00, 8'hFF, 8'h00, 8'h28, 8'h28, 8'h83},
      {8'hFF, 8'hFF, 8'h00, 8'hF0, 8'h0F, 8'h80},
      {8'h00, 8'hFF, 8'h80, 8'h81, 8'h81, 8'hC7},
      {8'h00, 8'h7E, 8'h00, 8'h81, 8'h81, 8'h00},
      {8'h0F, 8'hFF, 8'h30, 8'h3F, 8'h30, 8'hC4},
      {8'hAA, 8'h0C, 8'h08, 8'hAE, 8'h04, 8'h82}
   };

   task automatic tick(int n = 1);
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      tick();
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] req_word();
      return irq_req ? {1'b1, irq_hi, 3'b000, irq_vec} : 8'h00;
   endfunction

   task automatic pulse_ack();
      ack = 1'b1; tick(); ack = 1'b0;
   endtask

   task automatic pulse_ret();
      ret = 1'b1; tick(); ret = 1'b0;
   endtask

   initial begin
      #200000;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [7:0] d;
      tick(2);
      rst_n = 1'b1;
      tick();
      // R1 reset state
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), d);
         chk("R1 reset register", d, 8'h00);
      end
      chk("R1 reset request", req_word(), 8'h00);

      // R2 register write and read back
      wr(2'd3, 8'h5A);
      rd(2'd3, d);
      chk("R2 priority readback", d, 8'h5A);
      wr(2'd3, 8'h00);

      // table walk: R3 sense polarity, R5 gating, R6 arbitration
      for (int i = 0; i < 6; i++) begin
         logic [47:0] v;
         v = VEC[i];
         wr(2'd0, v[47:40]);
         wr(2'd2, v[39:32]);
         wr(2'd3, v[31:24]);
         pins = v[47:40];
         tick(4);
         wr(2'd1, 8'h00);
         pins = v[23:16];
         tick(4);
         rd(2'd1, d);
         chk("R3 flags from pin transitions", d, v[15:8]);
         chk("R6 presented request", req_word(), v[7:0]);
      end

      // R4: hardware set against a software clear in the same cycle
      wr(2'd0, 8'h00); wr(2'd2, 8'h00); wr(2'd3, 8'h00);
      pins = 8'h00;
      tick(4);
      wr(2'd1, 8'h00);
      pins = 8'h02;
      tick(2);
      wr(2'd1, 8'h00);
      rd(2'd1, d);
      chk("R4 set wins over clear", d, 8'h02);
      wr(2'd1, 8'h03);
      rd(2'd1, d);
      chk("R4 software set", d, 8'h03);
      wr(2'd1, 8'h00);
      // R3 level held: no new flag
      tick(5);
      rd(2'd1, d);
      chk("R3 held level no re-set", d, 8'h00);
      // R3 sense change alone sets nothing
      wr(2'd0, 8'h02);
      tick(4);
      rd(2'd1, d);
      chk("R3 sense rewrite no flag", d, 8'h00);
      pins = 8'h00;
      tick(3);
      rd(2'd1, d);
      chk("R3 falling edge with sense 1", d, 8'h02);

      // R7 R8 R9 nesting
      wr(2'd0, 8'h00); wr(2'd2, 8'hFF); wr(2'd3, 8'h04);
      tick(4);
      wr(2'd1, 8'h01);
      chk("R6 low request vec0", req_word(), 8'h80);
      pulse_ack();
      chk("R7 low in service hides low", req_word(), 8'h00);
      rd(2'd1, d);
      chk("R8 ack keeps flag", d, 8'h01);
      wr(2'd1, 8'h05);
      chk("R7 high pre-empts low", req_word(), 8'hC2);
      pulse_ack();
      wr(2'd3, 8'h0C);
      wr(2'd1, 8'h0D);
      chk("R7 nothing pre-empts high", req_word(), 8'h00);
      pulse_ret();
      chk("R9 return ends high service", req_word(), 8'hC2);
      wr(2'd1, 8'h01);
      chk("R7 low still in service", req_word(), 8'h00);
      pulse_ret();
      chk("R9 return ends low service", req_word(), 8'h80);

      // R5 global enable
      glb_en = 1'b0;
      #1;
      chk("R5 global enable off", req_word(), 8'h00);
      glb_en = 1'b1;

      // R10 wake
      wr(2'd1, 8'h00);
      wr(2'd2, 8'h10);
      wr(2'd0, 8'h00);
      pins = 8'h00;
      power_down = 1'b1;
      #1;
      chk("R10 wake idle", wake, 1'b0);
      pins = 8'h10;
      #1;
      chk("R10 wake on active pin", wake, 1'b1);
      power_down = 1'b0;
      #1;
      chk("R10 wake off when running", wake, 1'b0);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule